// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block turns a 32-bit effective address into a real page address using sixteen segment registers and a page-table base register. The top four address bits pick a segment register. Per-class enable inputs decide whether translation applies at all. When it does, the segment entry selects one of several outcomes. An ordinary segment gets a page-table lookup. A segment with no-execute set blocks code fetches. A direct-store segment follows its own pass-through rules.

For a lookup, the block builds a 30-bit compare tag, a protection key and two group addresses. It then drives an external group searcher through a request/response handshake. The primary group is searched first. The secondary group is searched only when the primary search does not grant. The block reports a one-cycle `done` pulse with a real address, a rights field and a 3-bit status. The segment registers and the table base register are loaded through a simple write port.

The controller is a four-state machine. `S_IDLE` accepts a request. `S_PRIMARY` and `S_SECONDARY` each hold a search request open until the searcher answers. `S_REPORT` drives `done` for one cycle. Transitions:
- idle→report: the request needs no search.
- idle→primary: the request needs a search.
- primary→report: the primary search grants.
- primary→secondary: the primary search misses or denies.
- secondary→report: any secondary answer.
- report→idle: always.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `done` and `srch_req` are 0, and all segment registers and the table base read as zero (a lookup made before any write uses group address 0x00000000 | hash and a tag built from VSID 0).
- R2: When translation is off for the access class (`xen_code`=0 for class CODE=1; `xen_data`=0 for any other class), the result is `done` one cycle after acceptance with status OK=0, real address = address with bits 11:0 cleared, rights=2'b11 (bit0 read, bit1 write), and no search.
- R3: The segment register is chosen by address bits 31:28. A config write with `cfg_sel` 0..15 loads that segment and 16 loads the table base. Any other select value changes nothing.
- R4: The key sent as `srch_key` is 1 when segment bit 29 is set and `user_mode`=1, or segment bit 30 is set and `user_mode`=0; otherwise it is 0. `srch_write` is `req_write`, forced to 0 for class CODE.
- R5: A CODE fetch (translation on) from a segment with bit 31 clear and bit 28 set ends with status NO_EXEC=4, real address 0, rights 0, and no search.
- R6: The primary search uses `srch_hsel`=0. Its group address is (base & 0xFFFF0000) | (H & M), where V = segment bits 23:0, P = address bits 27:12, H = ((V ^ P) & 0x7FFFF) << 6 and M = (base[8:0] << 16) | 0xFFC0. The tag is {V, P[15:10]}.
- R7: When the primary answer (`srch_status`: 0 grant, 1 miss, 2 deny) is not a grant, a secondary search follows with `srch_hsel`=1, hash (~H) & 0x01FFFFC0, the same mask and the same tag.
- R8: A grant ends with status OK, real address {`srch_rpn`, 12'h000} and rights = `srch_rights`. If the secondary answer is a miss, the primary outcome is kept (deny→PROT=3, miss→NOT_FOUND=2), otherwise the secondary outcome is used. Failures report real address 0 and rights 0.
- R9: For a direct-store segment (bit 31 set), a class INT=0 access passes untranslated (real address = full address). A read is allowed when key=0 and a write is allowed when key=1. An allowed access gives status DS_OK=1 with rights 2'b01 (read) or 2'b10 (write). A refused access gives PROT=3 with real address 0.
- R10: For a direct-store segment, class CACHE=4 gives status OK with real address = full address and rights 0. Classes CODE=1, FLOAT=2, RES=3 and EXT=5 give DS_ERR=5 with real address 0 and rights 0.
- R11: `done` lasts exactly one cycle. `req_valid` is ignored while a translation is in progress. `srch_req` stays high with steady group, tag and hash select until `srch_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_sel | input | 5 | 0..15 segment register, 16 table base |
| cfg_wdata | input | 32 | Config write data |
| xen_code | input | 1 | Translation enable for code fetches |
| xen_data | input | 1 | Translation enable for data accesses |
| user_mode | input | 1 | 1 = user, 0 = supervisor |
| req_valid | input | 1 | Start a translation (accepted in S_IDLE) |
| req_addr | input | 32 | Effective address |
| req_write | input | 1 | 1 = store access |
| req_class | input | 3 | 0 INT, 1 CODE, 2 FLOAT, 3 RES, 4 CACHE, 5 EXT |
| srch_req | output | 1 | Group search request, held until answered |
| srch_hsel | output | 1 | 0 primary, 1 secondary hash |
| srch_group | output | 32 | Group address to search |
| srch_tag | output | 30 | Compare tag |
| srch_key | output | 1 | Protection key |
| srch_write | output | 1 | Access direction for rights checking |
| srch_done | input | 1 | Searcher answer valid |
| srch_status | input | 2 | 0 grant, 1 miss, 2 deny |
| srch_rpn | input | 20 | Real page number on grant |
| srch_rights | input | 2 | Rights on grant (bit0 read, bit1 write) |
| done | output | 1 | One-cycle result strobe |
| status | output | 3 | 0 OK, 1 DS_OK, 2 NOT_FOUND, 3 PROT, 4 NO_EXEC, 5 DS_ERR |
| real_addr | output | 32 | Real address |
| rights | output | 2 | Granted rights (bit0 read, bit1 write) |

## Verification
The bench tests both enable inputs. Code and data accesses are sent with only one class disabled at a time, which shows that the enables are not swapped or merged. The searcher is answered with each combination that matters: primary grant, miss then grant, deny then miss, miss then miss, and miss then deny. Together these separate "keep the primary result" from "take the secondary result". The searcher side also checks the group address, the tag and the key for segments with different VSIDs and key bits, and under a table base with nonzero size bits, so that a wrong field slice or mask shows up. Direct-store segments are tried with each access class and with both read and write under both key values. This exercises the reversed rights rule and the class split.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int VSID_W     = 24;
    localparam int PIDX_W     = 16;
    localparam int API_W      = 6;
    localparam int HASH_W     = 19;
    localparam int GRP_SHIFT  = 6;
    localparam int LOW_W      = 16;
    localparam int TAG_W      = VSID_W + API_W;
    localparam int RPN_W      = VA_W - PAGE_SHIFT;
    localparam int CTL_W      = 4;

    typedef enum logic [2:0] {
        CL_INT   = 3'd0,
        CL_CODE  = 3'd1,
        CL_FLOAT = 3'd2,
        CL_RES   = 3'd3,
        CL_CACHE = 3'd4,
        CL_EXT   = 3'd5
    } acc_class_e;

    typedef enum logic [2:0] {
        ST_OK        = 3'd0,
        ST_DS_OK     = 3'd1,
        ST_NOT_FOUND = 3'd2,
        ST_PROT      = 3'd3,
        ST_NO_EXEC   = 3'd4,
        ST_DS_ERR    = 3'd5
    } xl_status_e;

    typedef enum logic [1:0] {
        SR_GRANT = 2'd0,
        SR_MISS  = 2'd1,
        SR_DENY  = 2'd2
    } srch_resp_e;

    typedef enum logic [2:0] {
        PL_BYPASS,
        PL_SEARCH,
        PL_NO_EXEC,
        PL_DS_GRANT,
        PL_DS_DENY,
        PL_DS_PASS,
        PL_DS_FAIL
    } plan_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PRIMARY,
        S_SECONDARY,
        S_REPORT
    } fsm_e;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
    parameter int NSEG = 16,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NSEG),
    localparam int SW  = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_seg,
    output logic [DW-1:0] tbl_base
);

    logic [DW-1:0] seg_arr [NSEG];

    genvar g;
    generate
        for (g = 0; g < NSEG; g++) begin : g_seg
            logic [DW-1:0] ent_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ent_q <= '0;
                end else if (wr_en && wr_sel == SW'(g)) begin
                    ent_q <= wr_data;
                end
            end
            assign seg_arr[g] = ent_q;
        end
    endgenerate

    logic [DW-1:0] base_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_en && wr_sel == SW'(NSEG)) begin
            base_q <= wr_data;
        end
    end

    assign rd_seg   = seg_arr[rd_idx];
    assign tbl_base = base_q;

endmodule

// File: rtl/seg_hash.sv
module seg_hash
    import seg_xlate_pkg::*;
(
    input  logic [VSID_W-1:0]       vsid,
    input  logic [PIDX_W-1:0]       pidx,
    input  logic [VA_W-LOW_W-1:0]   base_hi,
    input  logic [HASH_W+GRP_SHIFT-LOW_W-1:0] base_sz,
    output logic [VA_W-1:0]         pri_group,
    output logic [VA_W-1:0]         sec_group,
    output logic [TAG_W-1:0]        tag
);

    localparam int HM_W = HASH_W + GRP_SHIFT;
    localparam int SZ_W = HM_W - LOW_W;

    logic [HASH_W-1:0] fold;
    logic [HM_W-1:0]   pri_h;
    logic [HM_W-1:0]   sec_h;
    logic [HM_W-1:0]   mask;
    logic [VA_W-1:0]   base_top;

    assign fold     = vsid[HASH_W-1:0] ^ HASH_W'(pidx);
    assign pri_h    = {fold, {GRP_SHIFT{1'b0}}};
    assign sec_h    = {~fold, {GRP_SHIFT{1'b0}}};
    assign mask     = {base_sz[SZ_W-1:0], {(LOW_W-GRP_SHIFT){1'b1}}, {GRP_SHIFT{1'b0}}};
    assign base_top = {base_hi, {LOW_W{1'b0}}};

    assign pri_group = base_top | VA_W'(pri_h & mask);
    assign sec_group = base_top | VA_W'(sec_h & mask);
    assign tag       = {vsid, pidx[PIDX_W-1 -: API_W]};

endmodule

// File: rtl/seg_classify.sv
module seg_classify
    import seg_xlate_pkg::*;
(
    input  logic [CTL_W-1:0] seg_ctl,
    input  logic [2:0]       cls,
    input  logic             wr,
    input  logic             user,
    input  logic             xen_code,
    input  logic             xen_data,
    output plan_e            plan,
    output logic             key,
    output logic             eff_write
);

    logic       is_code;
    logic       ds_seg;
    logic       noexec;
    acc_class_e c;

    assign c         = acc_class_e'(cls);
    assign is_code   = (c == CL_CODE);
    assign ds_seg    = seg_ctl[3];
    assign noexec    = seg_ctl[0];
    assign key       = (seg_ctl[1] & user) | (seg_ctl[2] & ~user);
    assign eff_write = wr & ~is_code;

    always_comb begin
        plan = PL_SEARCH;
        if (is_code ? !xen_code : !xen_data) begin
            plan = PL_BYPASS;
        end else if (ds_seg) begin
            unique case (c)
                CL_INT: begin
                    if (eff_write ? key : !key) plan = PL_DS_GRANT;
                    else                        plan = PL_DS_DENY;
                end
                CL_CACHE: plan = PL_DS_PASS;
                default:  plan = PL_DS_FAIL;
            endcase
        end else if (is_code && noexec) begin
            plan = PL_NO_EXEC;
        end
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int NSEG = 16,
    localparam int IW  = $clog2(NSEG),
    localparam int SW  = IW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [SW-1:0]       cfg_sel,
    input  logic [VA_W-1:0]     cfg_wdata,
    input  logic                xen_code,
    input  logic                xen_data,
    input  logic                user_mode,
    input  logic                req_valid,
    input  logic [VA_W-1:0]     req_addr,
    input  logic                req_write,
    input  logic [2:0]          req_class,
    output logic                srch_req,
    output logic                srch_hsel,
    output logic [VA_W-1:0]     srch_group,
    output logic [TAG_W-1:0]    srch_tag,
    output logic                srch_key,
    output logic                srch_write,
    input  logic                srch_done,
    input  logic [1:0]          srch_status,
    input  logic [RPN_W-1:0]    srch_rpn,
    input  logic [1:0]          srch_rights,
    output logic                done,
    output logic [2:0]          status,
    output logic [VA_W-1:0]     real_addr,
    output logic [1:0]          rights
);

    localparam int HM_W = HASH_W + GRP_SHIFT;

    logic [VA_W-1:0]   seg_live;
    logic [VA_W-1:0]   base;
    plan_e             plan;
    logic              key_live;
    logic              wr_live;

    fsm_e              state_q, state_d;
    logic [VSID_W-1:0] vsid_q;
    logic [PIDX_W-1:0] pidx_q;
    logic              key_q;
    logic              wr_q;
    logic              pri_deny_q;
    logic [2:0]        st_q;
    logic [VA_W-1:0]   ra_q;
    logic [1:0]        rt_q;

    logic [VA_W-1:0]   grp_pri, grp_sec;
    logic [TAG_W-1:0]  tag_w;
    srch_resp_e        resp;
    logic              accept;

    logic unused_bits;
    assign unused_bits = ^{seg_live[VA_W-CTL_W-1:VSID_W], base[LOW_W-1:HM_W-LOW_W]};

    seg_regfile #(.NSEG(NSEG), .DW(VA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_sel   (cfg_sel),
        .wr_data  (cfg_wdata),
        .rd_idx   (req_addr[VA_W-1 -: IW]),
        .rd_seg   (seg_live),
        .tbl_base (base)
    );

    seg_classify u_cls (
        .seg_ctl   (seg_live[VA_W-1 -: CTL_W]),
        .cls       (req_class),
        .wr        (req_write),
        .user      (user_mode),
        .xen_code  (xen_code),
        .xen_data  (xen_data),
        .plan      (plan),
        .key       (key_live),
        .eff_write (wr_live)
    );

    seg_hash u_hash (
        .vsid      (vsid_q),
        .pidx      (pidx_q),
        .base_hi   (base[VA_W-1:LOW_W]),
        .base_sz   (base[HM_W-LOW_W-1:0]),
        .pri_group (grp_pri),
        .sec_group (grp_sec),
        .tag       (tag_w)
    );

    assign resp   = srch_resp_e'(srch_status);
    assign accept = (state_q == S_IDLE) && req_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    state_d = (plan == PL_SEARCH) ? S_PRIMARY : S_REPORT;
                end
            end
            S_PRIMARY: begin
                if (srch_done) begin
                    state_d = (resp == SR_GRANT) ? S_REPORT : S_SECONDARY;
                end
            end
            S_SECONDARY: begin
                if (srch_done) state_d = S_REPORT;
            end
            S_REPORT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Request capture and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vsid_q     <= '0;
            pidx_q     <= '0;
            key_q      <= 1'b0;
            wr_q       <= 1'b0;
            pri_deny_q <= 1'b0;
            st_q       <= ST_OK;
            ra_q       <= '0;
            rt_q       <= '0;
        end else begin
            if (accept) begin
                vsid_q <= seg_live[VSID_W-1:0];
                pidx_q <= req_addr[PAGE_SHIFT +: PIDX_W];
                key_q  <= key_live;
                wr_q   <= wr_live;
                ra_q   <= '0;
                rt_q   <= '0;
                unique case (plan)
                    PL_BYPASS: begin
                        st_q <= ST_OK;
                        ra_q <= {req_addr[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
                        rt_q <= 2'b11;
                    end
                    PL_NO_EXEC:  st_q <= ST_NO_EXEC;
                    PL_DS_GRANT: begin
                        st_q <= ST_DS_OK;
                        ra_q <= req_addr;
                        rt_q <= wr_live ? 2'b10 : 2'b01;
                    end
                    PL_DS_DENY: st_q <= ST_PROT;
                    PL_DS_PASS: begin
                        st_q <= ST_OK;
                        ra_q <= req_addr;
                    end
                    PL_DS_FAIL: st_q <= ST_DS_ERR;
                    default:    st_q <= ST_NOT_FOUND;
                endcase
            end
            if (srch_done && (state_q == S_PRIMARY || state_q == S_SECONDARY)) begin
                if (resp == SR_GRANT) begin
                    st_q <= ST_OK;
                    ra_q <= {srch_rpn, {PAGE_SHIFT{1'b0}}};
                    rt_q <= srch_rights;
                end else if (state_q == S_PRIMARY) begin
                    pri_deny_q <= (resp != SR_MISS);
                end else if (resp == SR_MISS) begin
                    st_q <= pri_deny_q ? ST_PROT : ST_NOT_FOUND;
                    ra_q <= '0;
                    rt_q <= '0;
                end else begin
                    st_q <= ST_PROT;
                    ra_q <= '0;
                    rt_q <= '0;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        srch_req   = 1'b0;
        srch_hsel  = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            S_PRIMARY:   srch_req = 1'b1;
            S_SECONDARY: begin
                srch_req  = 1'b1;
                srch_hsel = 1'b1;
            end
            S_REPORT:    done = 1'b1;
            default:     ;
        endcase
        srch_group = srch_hsel ? grp_sec : grp_pri;
        srch_tag   = tag_w;
        srch_key   = key_q;
        srch_write = wr_q;
        status     = st_q;
        real_addr  = ra_q;
        rights     = rt_q;
    end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        srch_req,
    input logic        srch_hsel,
    input logic [31:0] srch_group,
    input logic [29:0] srch_tag,
    input logic        srch_done,
    input logic [1:0]  srch_status,
    input logic        done,
    input logic [2:0]  status,
    input logic [31:0] real_addr,
    input logic [1:0]  rights
);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_no_search_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !srch_req);

    a_r11_search_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_req && !srch_done) |=> (srch_req && $stable(srch_group)
                                      && $stable(srch_tag) && $stable(srch_hsel)));

    a_r8_grant_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_req && srch_done && srch_status == 2'd0) |=> done);

    a_r7_secondary_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_req && srch_done && !srch_hsel && srch_status != 2'd0) |=> (srch_req && srch_hsel));

    a_r5_noexec_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 3'd4) |-> (real_addr == 32'd0 && rights == 2'd0));

    a_r2_full_rights_page: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rights == 2'b11) |-> (status == 3'd0 && real_addr[11:0] == 12'd0));

    a_r9_ds_single_right: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 3'd1) |-> ($countones(rights) == 1));

    always_comb begin
        a_r1_status_range: assert (!rst_n || !done || status <= 3'd5);
    end

endmodule

bind seg_xlate seg_xlate_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .srch_req    (srch_req),
    .srch_hsel   (srch_hsel),
    .srch_group  (srch_group),
    .srch_tag    (srch_tag),
    .srch_done   (srch_done),
    .srch_status (srch_status),
    .done        (done),
    .status      (status),
    .real_addr   (real_addr),
    .rights      (rights)
);

// File: tb/seg_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_tb_top;

    localparam logic [2:0] C_INT = 3'd0, C_CODE = 3'd1, C_FLT = 3'd2,
                           C_RES = 3'd3, C_CACHE = 3'd4, C_EXT = 3'd5;
    localparam logic [2:0] S_OK = 3'd0, S_DSOK = 3'd1, S_NF = 3'd2,
                           S_PROT = 3'd3, S_NX = 3'd4, S_DSE = 3'd5;
    localparam logic [1:0] R_GRANT = 2'd0, R_MISS = 2'd1, R_DENY = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        xen_code = 1'b1, xen_data = 1'b1, user_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [2:0]  req_class = '0;
    logic        srch_req, srch_hsel, srch_key, srch_write;
    logic [31:0] srch_group;
    logic [29:0] srch_tag;
    logic        srch_done = 1'b0;
    logic [1:0]  srch_status = '0;
    logic [19:0] srch_rpn = '0;
    logic [1:0]  srch_rights = '0;
    logic        done;
    logic [2:0]  status;
    logic [31:0] real_addr;
    logic [1:0]  rights;

    int nchk = 0;
    int nbad = 0;
    logic [31:0] sh_seg [16];
    logic [31:0] sh_base = '0;

    always #10 clk = ~clk;

    seg_xlate dut_i (.*);

    function automatic logic [31:0] e_grp(input logic [31:0] s, input logic [31:0] a,
                                          input logic [31:0] b, input bit sec);
        logic [18:0] f;
        logic [24:0] h, m;
        f = s[18:0] ^ {3'b0, a[27:12]};
        h = sec ? {~f, 6'b0} : {f, 6'b0};
        m = {b[8:0], 16'hFFC0};
        return (b & 32'hFFFF0000) | {7'b0, h & m};
    endfunction

    function automatic logic [29:0] e_tag(input logic [31:0] s, input logic [31:0] a);
        return {s[23:0], a[27:22]};
    endfunction

    function automatic logic e_key(input logic [31:0] s, input logic u);
        return (s[29] & u) | (s[30] & ~u);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [4:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (sel < 5'd16) sh_seg[sel[3:0]] = d;
        else if (sel == 5'd16) sh_base = d;
    endtask

    task automatic send(input logic [31:0] a, input logic w, input logic [2:0] c);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_class = c;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic serve(input string r, input bit sec, input logic [31:0] a,
                         input logic w, input logic [1:0] resp,
                         input logic [19:0] rpn, input logic [1:0] rts);
        logic [31:0] s;
        bit seen;
        s = sh_seg[a[31:28]];
        seen = 0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            seen = srch_req;
        end
        chk({r, " search request"}, 32'(seen), 32'd1);
        chk({r, " hash select"}, 32'(srch_hsel), 32'(sec));
        chk({r, " group"}, srch_group, e_grp(s, a, sh_base, sec));
        chk({r, " tag"}, 32'(srch_tag), 32'(e_tag(s, a)));
        chk({r, " key"}, 32'(srch_key), 32'(e_key(s, user_mode)));
        chk({r, " direction"}, 32'(srch_write), 32'(w));
        srch_done = 1'b1; srch_status = resp; srch_rpn = rpn; srch_rights = rts;
        @(posedge clk); #1;
        srch_done = 1'b0;
    endtask

    task automatic finish_check(input string r, input logic [2:0] st,
                                input logic [31:0] ra, input logic [1:0] rt,
                                input bit expect_search);
        bit got;
        bit searched;
        got = 0;
        searched = 0;
        for (int i = 0; i < 20 && !got; i++) begin
            @(negedge clk);
            got = done;
            if (srch_req) searched = 1;
        end
        chk({r, " done seen"}, 32'(got), 32'd1);
        chk({r, " status"}, 32'(status), 32'(st));
        chk({r, " real address"}, real_addr, ra);
        chk({r, " rights"}, 32'(rights), 32'(rt));
        if (!expect_search) chk({r, " no search made"}, 32'(searched), 32'd0);
        @(negedge clk);
        chk({r, " done single cycle"}, 32'(done), 32'd0);
    endtask

    // R1: reset state and zeroed registers
    task automatic t_reset;
        chk("R1 done after reset", 32'(done), 32'd0);
        chk("R1 srch_req after reset", 32'(srch_req), 32'd0);
        send(32'h7654_3000, 1'b0, C_INT);
        serve("R1 zero regs", 0, 32'h7654_3000, 1'b0, R_GRANT, 20'h00001, 2'b01);
        finish_check("R1 zero regs", S_OK, 32'h0000_1000, 2'b01, 1);
    endtask

    // R2: bypass per access class
    task automatic t_bypass;
        xen_data = 1'b0;
        send(32'h1234_5678, 1'b1, C_INT);
        finish_check("R2 data bypass", S_OK, 32'h1234_5000, 2'b11, 0);
        send(32'hFFFF_FFFF, 1'b0, C_FLT);
        finish_check("R2 data bypass float", S_OK, 32'hFFFF_F000, 2'b11, 0);
        xen_data = 1'b1;
        xen_code = 1'b0;
        send(32'h3ABC_DEF0, 1'b0, C_CODE);
        finish_check("R2 code bypass", S_OK, 32'h3ABC_D000, 2'b11, 0);
        xen_code = 1'b1;
    endtask

    // R5: no-execute segment
    task automatic t_noexec;
        cfg_write(5'd3, 32'h1000_0123);
        send(32'h3000_4000, 1'b0, C_CODE);
        finish_check("R5 noexec fetch", S_NX, 32'h0, 2'b00, 0);
        send(32'h3000_4000, 1'b0, C_INT);
        serve("R5 noexec data searches", 0, 32'h3000_4000, 1'b0, R_GRANT, 20'h12345, 2'b11);
        finish_check("R5 noexec data searches", S_OK, 32'h1234_5000, 2'b11, 1);
    endtask

    // R3, R4, R6, R8: primary hit with key and segment select
    task automatic t_primary;
        cfg_write(5'd16, 32'h0FA0_0003);
        cfg_write(5'd5, 32'h400A_BCDE);
        cfg_write(5'd6, 32'h2055_5555);
        send(32'h5123_4000, 1'b1, C_INT);
        serve("R6 primary hit", 0, 32'h5123_4000, 1'b1, R_GRANT, 20'hABCDE, 2'b10);
        finish_check("R8 primary hit", S_OK, 32'hABCD_E000, 2'b10, 1);
        send(32'h6FED_C000, 1'b1, C_CODE);
        serve("R4 code write forced read", 0, 32'h6FED_C000, 1'b0, R_GRANT, 20'h00F0F, 2'b01);
        finish_check("R3 segment six", S_OK, 32'h00F0_F000, 2'b01, 1);
        user_mode = 1'b1;
        send(32'h6001_2000, 1'b0, C_INT);
        serve("R4 user key", 0, 32'h6001_2000, 1'b0, R_GRANT, 20'h00002, 2'b01);
        finish_check("R4 user key", S_OK, 32'h0000_2000, 2'b01, 1);
        send(32'h5001_2000, 1'b0, C_INT);
        serve("R4 user no key", 0, 32'h5001_2000, 1'b0, R_GRANT, 20'h00003, 2'b01);
        finish_check("R4 user no key", S_OK, 32'h0000_3000, 2'b01, 1);
        user_mode = 1'b0;
        cfg_write(5'd20, 32'hFFFF_FFFF);
        send(32'h5123_4000, 1'b0, C_INT);
        serve("R3 bad select ignored", 0, 32'h5123_4000, 1'b0, R_GRANT, 20'h00004, 2'b01);
        finish_check("R3 bad select ignored", S_OK, 32'h0000_4000, 2'b01, 1);
    endtask

    // R7, R8: secondary search combinations
    task automatic t_secondary;
        send(32'h5ABC_D000, 1'b0, C_INT);
        serve("R7 miss then", 0, 32'h5ABC_D000, 1'b0, R_MISS, 20'h0, 2'b00);
        serve("R7 secondary grant", 1, 32'h5ABC_D000, 1'b0, R_GRANT, 20'h55AA5, 2'b01);
        finish_check("R8 secondary grant", S_OK, 32'h55AA_5000, 2'b01, 1);
        send(32'h5ABC_D000, 1'b1, C_INT);
        serve("R7 deny then", 0, 32'h5ABC_D000, 1'b1, R_DENY, 20'h0, 2'b00);
        serve("R7 secondary miss", 1, 32'h5ABC_D000, 1'b1, R_MISS, 20'h0, 2'b00);
        finish_check("R8 deny kept", S_PROT, 32'h0, 2'b00, 1);
        send(32'h5ABC_D000, 1'b0, C_INT);
        serve("R7 miss first", 0, 32'h5ABC_D000, 1'b0, R_MISS, 20'h0, 2'b00);
        serve("R7 miss second", 1, 32'h5ABC_D000, 1'b0, R_MISS, 20'h0, 2'b00);
        finish_check("R8 double miss", S_NF, 32'h0, 2'b00, 1);
        send(32'h5ABC_D000, 1'b0, C_INT);
        serve("R7 miss before deny", 0, 32'h5ABC_D000, 1'b0, R_MISS, 20'h0, 2'b00);
        serve("R7 secondary deny", 1, 32'h5ABC_D000, 1'b0, R_DENY, 20'h0, 2'b00);
        finish_check("R8 secondary deny", S_PROT, 32'h0, 2'b00, 1);
    endtask

    // R9, R10: direct-store segments
    task automatic t_direct;
        cfg_write(5'd9, 32'h8000_0000);
        cfg_write(5'd10, 32'hC000_0000);
        send(32'h9000_0ABC, 1'b0, C_INT);
        finish_check("R9 ds read key0", S_DSOK, 32'h9000_0ABC, 2'b01, 0);
        send(32'h9000_0ABC, 1'b1, C_INT);
        finish_check("R9 ds write key0", S_PROT, 32'h0, 2'b00, 0);
        send(32'hA111_2223, 1'b1, C_INT);
        finish_check("R9 ds write key1", S_DSOK, 32'hA111_2223, 2'b10, 0);
        send(32'hA111_2223, 1'b0, C_INT);
        finish_check("R9 ds read key1", S_PROT, 32'h0, 2'b00, 0);
        send(32'h9876_5432, 1'b1, C_CACHE);
        finish_check("R10 ds cache", S_OK, 32'h9876_5432, 2'b00, 0);
        send(32'h9000_1000, 1'b0, C_CODE);
        finish_check("R10 ds code", S_DSE, 32'h0, 2'b00, 0);
        send(32'h9000_1000, 1'b0, C_FLT);
        finish_check("R10 ds float", S_DSE, 32'h0, 2'b00, 0);
        send(32'h9000_1000, 1'b0, C_RES);
        finish_check("R10 ds reserved", S_DSE, 32'h0, 2'b00, 0);
        send(32'h9000_1000, 1'b1, C_EXT);
        finish_check("R10 ds external", S_DSE, 32'h0, 2'b00, 0);
    endtask

    // R11: request ignored while busy
    task automatic t_busy;
        bit extra;
        send(32'h5000_8000, 1'b0, C_INT);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h9000_0000; req_write = 1'b0; req_class = C_INT;
        @(posedge clk); #1;
        req_valid = 1'b0;
        serve("R11 busy search", 0, 32'h5000_8000, 1'b0, R_GRANT, 20'h0BEEF, 2'b01);
        finish_check("R11 busy result", S_OK, 32'h0BEE_F000, 2'b01, 1);
        extra = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (done || srch_req) extra = 1;
        end
        chk("R11 busy request dropped", 32'(extra), 32'd0);
    endtask

    bit wd_hit = 0;
    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        wd_hit = 1;
        nchk++;
        nbad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) sh_seg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_noexec();
        t_primary();
        t_secondary();
        t_direct();
        t_busy();
        if (!wd_hit) begin
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

endmodule